// File: doc/BRIEF.md
# Double-Precision to Signed Integer Rounding Converter

This block turns a 64-bit IEEE-754 double into a signed two's-complement integer of either 32 or 64 bits. The caller picks one of four explicit rounding operations (nearest, toward zero, toward minus infinity, toward plus infinity) or a plain convert operation that follows the current rounding-mode field. Alongside the integer it reports whether the conversion was invalid and whether it lost precision.

Operands arrive on a valid/ready stream and results leave on a second valid/ready stream, one register stage apart. The input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). This gives full throughput with `out_ready` held high, and a stall that holds the result steady when `out_ready` is low. A result is consumed on an edge where `out_valid` and `out_ready` are both high.

The nearest operation breaks exact ties in a different way at each width. At 32 bits a tie goes to the even neighbour. At 64 bits a tie goes away from zero. If the rounded value does not fit, or the input is a NaN or an infinity, the result is replaced by the largest positive integer of the selected width.

Top module: `dbl_to_int_cvt`

## Requirements
- R1: A transfer on the input stream produces `out_valid` on the next clock edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result and flags stay unchanged.
- R2: Operation code 0 (nearest) with `in_wide`=0 rounds to the nearest integer, and an exact halfway value goes to the even integer (2.5 gives 2, 3.5 gives 4, -2.5 gives -2).
- R3: Operation code 0 with `in_wide`=1 rounds to the nearest integer, and an exact halfway value goes away from zero (2.5 gives 3, -2.5 gives -3).
- R4: Operation codes 1, 2 and 3 round toward zero, toward minus infinity and toward plus infinity, at both widths.
- R5: Operation code 4 (convert) with `in_rmode`=0 gives exactly the nearest result of the same width. With any non-zero `in_rmode` it is invalid.
- R6: NaN, infinities, and rounded values outside the selected signed range set `out_invalid`=1 and `out_inexact`=0. The result is then 0x7FFFFFFFFFFFFFFF at 64 bits, or 0x000000007FFFFFFF at 32 bits.
- R7: `out_inexact` is 1 exactly when the rounded integer differs from the input and the conversion is not invalid.
- R8: `in_wide`=1 selects a 64-bit result. With `in_wide`=0 the 32-bit result is sign-extended onto all 64 bits of `out_result`.
- R9: Operation codes 5, 6 and 7 are reserved and give the invalid result of R6.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.
- R11: A signed zero converts to 0 with no flag. A subnormal converts to 0, or to +1 or -1 where the rounding direction requires it, with `out_inexact`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Operand stream ready |
| in_operand | input | 64 | Double-precision operand |
| in_op | input | 3 | Operation: 0 nearest, 1 toward zero, 2 floor, 3 ceiling, 4 convert, 5-7 reserved |
| in_wide | input | 1 | 1 = 64-bit result, 0 = 32-bit result |
| in_rmode | input | 2 | Current rounding-mode field, used by convert |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_result | output | 64 | Signed integer result (32-bit results sign-extended) |
| out_invalid | output | 1 | Conversion invalid; result holds the substitution pattern |
| out_inexact | output | 1 | Rounded value differs from the operand |

## Verification
Halfway values such as ±2.5 and 3.5 are sent at both widths, which separates ties-to-even from ties-away and catches a nearest mode that ignores the width. ±1.5 under each directed operation separates the four directions by sign. Values straddling ±2^31 and ±2^63, together with NaN, infinities, signed zero and subnormals, exercise the range check, its asymmetric negative limit and the exact/inexact flag. A few hundred random quarter- and sixteenth-step values at random widths and operations, sent with a periodically dropped `out_ready`, test the rounding paths together with back-pressure.

// File: rtl/dbl_cvt_pkg.sv
package dbl_cvt_pkg;
  localparam int DBL_EXP_W   = 11;
  localparam int DBL_FRAC_W  = 52;
  localparam int INT_WIDE_W  = 64;
  localparam int INT_NARROW_W = 32;

  typedef enum logic [2:0] {
    OP_NEAREST = 3'd0,
    OP_TRUNC   = 3'd1,
    OP_FLOOR   = 3'd2,
    OP_CEIL    = 3'd3,
    OP_CONVERT = 3'd4
  } cvt_op_e;
endpackage

// File: rtl/dbl_split.sv
// Splits a finite double into integer magnitude, guard bit and sticky bit.
module dbl_split #(
  parameter int EXP_W  = dbl_cvt_pkg::DBL_EXP_W,
  parameter int FRAC_W = dbl_cvt_pkg::DBL_FRAC_W,
  parameter int RES_W  = dbl_cvt_pkg::INT_WIDE_W
) (
  input  logic [EXP_W+FRAC_W:0] operand,
  output logic                  sign,
  output logic                  nonfinite,
  output logic                  too_big,
  output logic [RES_W-1:0]      int_mag,
  output logic                  guard,
  output logic                  sticky
);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int MANT_W = FRAC_W + 1;
  localparam int FIX_W  = 2 * RES_W;
  localparam int PAD_W  = FIX_W - MANT_W;
  localparam int MAX_E  = RES_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic [FIX_W-1:0]  fix_src;
  logic [FIX_W-1:0]  fix_shifted;
  int                unb;
  int                shamt;

  assign sign      = operand[EXP_W+FRAC_W];
  assign exp_f     = operand[FRAC_W +: EXP_W];
  assign frac_f    = operand[FRAC_W-1:0];
  assign nonfinite = &exp_f;
  assign fix_src   = {1'b1, frac_f, {PAD_W{1'b0}}};

  always_comb begin
    unb         = int'(exp_f) - BIAS;
    shamt       = 0;
    fix_shifted = '0;
    too_big     = 1'b0;
    int_mag     = '0;
    guard       = 1'b0;
    sticky      = 1'b0;
    if (exp_f == '0) begin
      // zero or subnormal: magnitude far below one
      sticky = |frac_f;
    end else if (unb > MAX_E) begin
      too_big = 1'b1;
    end else if (unb < -RES_W) begin
      sticky = 1'b1;
    end else begin
      shamt       = MAX_E - unb;
      fix_shifted = fix_src >> shamt;
      int_mag     = fix_shifted[FIX_W-1:RES_W];
      guard       = fix_shifted[RES_W-1];
      sticky      = |fix_shifted[RES_W-2:0];
    end
  end
endmodule

// File: rtl/dbl_round_dir.sv
// Decides whether the truncated magnitude is incremented.
module dbl_round_dir (
  input  dbl_cvt_pkg::cvt_op_e op,
  input  logic                 wide,
  input  logic                 sign,
  input  logic                 lsb,
  input  logic                 guard,
  input  logic                 sticky,
  output logic                 round_up
);
  import dbl_cvt_pkg::*;
  logic frac_any;
  logic near_up;

  assign frac_any = guard | sticky;

  generate
    // wide results break ties away from zero, narrow ones toward even
    assign near_up = wide ? guard : (guard & (sticky | lsb));
  endgenerate

  always_comb begin
    unique case (op)
      OP_NEAREST, OP_CONVERT: round_up = near_up;
      OP_TRUNC:               round_up = 1'b0;
      OP_FLOOR:               round_up = sign & frac_any;
      OP_CEIL:                round_up = ~sign & frac_any;
      default:                round_up = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbl_fit_pack.sv
// Range check, sign application, width selection and invalid substitution.
module dbl_fit_pack #(
  parameter int RES_W    = dbl_cvt_pkg::INT_WIDE_W,
  parameter int NARROW_W = dbl_cvt_pkg::INT_NARROW_W
) (
  input  logic             sign,
  input  logic             wide,
  input  logic             force_invalid,
  input  logic [RES_W-1:0] mag,
  input  logic             round_up,
  input  logic             lost_bits,
  output logic [RES_W-1:0] result,
  output logic             invalid,
  output logic             inexact
);
  localparam int HI_PAD = RES_W - NARROW_W;

  localparam logic [RES_W:0] LIM_W_POS = {2'b00, {(RES_W-1){1'b1}}};
  localparam logic [RES_W:0] LIM_W_NEG = {2'b01, {(RES_W-1){1'b0}}};
  localparam logic [RES_W:0] LIM_N_POS = {{(HI_PAD+2){1'b0}}, {(NARROW_W-1){1'b1}}};
  localparam logic [RES_W:0] LIM_N_NEG = {{(HI_PAD+1){1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};
  localparam logic [RES_W-1:0] PAT_W   = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] PAT_N   = {{(HI_PAD+1){1'b0}}, {(NARROW_W-1){1'b1}}};

  logic [RES_W:0]   mag_r;
  logic [RES_W:0]   limit;
  logic [RES_W-1:0] signed_val;
  logic [RES_W-1:0] narrowed;
  logic             overflow;

  assign mag_r      = {1'b0, mag} + {{RES_W{1'b0}}, round_up};
  assign limit      = wide ? (sign ? LIM_W_NEG : LIM_W_POS)
                           : (sign ? LIM_N_NEG : LIM_N_POS);
  assign overflow   = mag_r > limit;
  assign signed_val = sign ? (~mag_r[RES_W-1:0] + 1'b1) : mag_r[RES_W-1:0];
  assign narrowed   = {{HI_PAD{signed_val[NARROW_W-1]}}, signed_val[NARROW_W-1:0]};

  assign invalid = force_invalid | overflow;
  assign inexact = lost_bits & ~invalid;

  always_comb begin
    if (invalid) result = wide ? PAT_W : PAT_N;
    else         result = wide ? signed_val : narrowed;
  end
endmodule

// File: rtl/dbl_to_int_cvt.sv
module dbl_to_int_cvt #(
  parameter int EXP_W    = dbl_cvt_pkg::DBL_EXP_W,
  parameter int FRAC_W   = dbl_cvt_pkg::DBL_FRAC_W,
  parameter int RES_W    = dbl_cvt_pkg::INT_WIDE_W,
  parameter int NARROW_W = dbl_cvt_pkg::INT_NARROW_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [EXP_W+FRAC_W:0] in_operand,
  input  logic [2:0]            in_op,
  input  logic                  in_wide,
  input  logic [1:0]            in_rmode,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [RES_W-1:0]      out_result,
  output logic                  out_invalid,
  output logic                  out_inexact
);
  import dbl_cvt_pkg::*;

  logic             sp_sign, sp_nonfinite, sp_too_big, sp_guard, sp_sticky;
  logic [RES_W-1:0] sp_mag;
  logic             rnd_up;
  logic             op_reserved, cvt_mode_bad, force_inv;
  logic [RES_W-1:0] fp_result;
  logic             fp_invalid, fp_inexact;
  logic             accept;
  cvt_op_e          op_e;

  logic             r_valid;
  logic [RES_W-1:0] r_result;
  logic             r_invalid, r_inexact;

  assign op_e         = cvt_op_e'(in_op);
  assign op_reserved  = in_op > 3'(OP_CONVERT);
  assign cvt_mode_bad = (op_e == OP_CONVERT) && (in_rmode != 2'd0);
  assign force_inv    = op_reserved | cvt_mode_bad | sp_nonfinite | sp_too_big;

  dbl_split #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .RES_W(RES_W)) u_split (
    .operand   (in_operand),
    .sign      (sp_sign),
    .nonfinite (sp_nonfinite),
    .too_big   (sp_too_big),
    .int_mag   (sp_mag),
    .guard     (sp_guard),
    .sticky    (sp_sticky)
  );

  dbl_round_dir u_dir (
    .op       (op_e),
    .wide     (in_wide),
    .sign     (sp_sign),
    .lsb      (sp_mag[0]),
    .guard    (sp_guard),
    .sticky   (sp_sticky),
    .round_up (rnd_up)
  );

  dbl_fit_pack #(.RES_W(RES_W), .NARROW_W(NARROW_W)) u_fit (
    .sign          (sp_sign),
    .wide          (in_wide),
    .force_invalid (force_inv),
    .mag           (sp_mag),
    .round_up      (rnd_up),
    .lost_bits     (sp_guard | sp_sticky),
    .result        (fp_result),
    .invalid       (fp_invalid),
    .inexact       (fp_inexact)
  );

  assign in_ready = ~r_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid   <= 1'b0;
      r_result  <= '0;
      r_invalid <= 1'b0;
      r_inexact <= 1'b0;
    end else begin
      if (accept) begin
        r_valid   <= 1'b1;
        r_result  <= fp_result;
        r_invalid <= fp_invalid;
        r_inexact <= fp_inexact;
      end else if (out_ready) begin
        r_valid <= 1'b0;
      end
    end
  end

  assign out_valid   = r_valid;
  assign out_result  = r_result;
  assign out_invalid = r_invalid;
  assign out_inexact = r_inexact;
endmodule

// File: rtl/dbl_to_int_cvt_chk.sv
module dbl_to_int_cvt_chk #(
  parameter int EXP_W  = dbl_cvt_pkg::DBL_EXP_W,
  parameter int FRAC_W = dbl_cvt_pkg::DBL_FRAC_W,
  parameter int RES_W  = dbl_cvt_pkg::INT_WIDE_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [EXP_W+FRAC_W:0] in_operand,
  input logic [2:0]            in_op,
  input logic [1:0]            in_rmode,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [RES_W-1:0]      out_result,
  input logic                  out_invalid,
  input logic                  out_inexact
);
  localparam logic [RES_W-1:0] PAT_W = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] PAT_N = {{(RES_W-31){1'b0}}, {31{1'b1}}};

  logic acc;
  assign acc = in_valid && in_ready;

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
      && $stable(out_invalid) && $stable(out_inexact)));

  p_flags_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));

  p_invalid_pattern_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_result == PAT_W || out_result == PAT_N));

  p_nonfinite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (&in_operand[FRAC_W +: EXP_W])) |=> out_invalid);

  p_cvt_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 3'd4 && in_rmode != 2'd0) |=> out_invalid);

  p_reserved_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op > 3'd4) |=> out_invalid);

  p_signed_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_operand[EXP_W+FRAC_W-1:0] == '0 && in_op <= 3'd3)
      |=> (out_result == '0 && !out_invalid && !out_inexact));
endmodule

bind dbl_to_int_cvt dbl_to_int_cvt_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .RES_W(RES_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_operand(in_operand), .in_op(in_op), .in_rmode(in_rmode),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_invalid(out_invalid), .out_inexact(out_inexact)
);

// File: tb/sim_dbl_to_int_cvt.sv
`timescale 1ns/1ps
module sim_dbl_to_int_cvt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_operand = '0;
  logic [2:0]  in_op = '0;
  logic        in_wide = 1'b0;
  logic [1:0]  in_rmode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_invalid, out_inexact;

  int          n_tests = 0;
  int          n_fail = 0;
  int          cyc = 0;
  int          drv_cyc = 0;
  bit          done = 0;
  bit          stall_en = 0;
  logic [65:0] exp_q[$];
  string       tag_q[$];
  string       cur_tag;

  always #4 clk = ~clk;  // 125 MHz

  dbl_to_int_cvt u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_op(in_op), .in_wide(in_wide),
    .in_rmode(in_rmode), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  // Behavioural reference built on real arithmetic
  function automatic logic [65:0] model(input logic [63:0] b, input logic [2:0] op,
                                        input logic wide, input logic [1:0] rm);
    real    x, r, a, f, d, lo, hi;
    bit     bad;
    longint v;
    x   = $bitstoreal(b);
    bad = (op > 3'd4) || (op == 3'd4 && rm != 2'd0) || (b[62:52] == 11'h7FF);
    r   = 0.0;
    if (!bad) begin
      case (op)
        3'd1: r = (x < 0.0) ? $ceil(x) : $floor(x);
        3'd2: r = $floor(x);
        3'd3: r = $ceil(x);
        default: begin
          if (wide) begin
            a = (x < 0.0) ? -x : x;
            f = $floor(a);
            d = a - f;
            r = (d >= 0.5) ? f + 1.0 : f;
            if (x < 0.0) r = -r;
          end else begin
            f = $floor(x);
            d = x - f;
            if (d > 0.5)      r = f + 1.0;
            else if (d < 0.5) r = f;
            else              r = ($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0;
          end
        end
      endcase
      lo = wide ? -9223372036854775808.0 : -2147483648.0;
      hi = wide ?  9223372036854775808.0 :  2147483648.0;
      if (r >= hi || r < lo) bad = 1;
    end
    if (bad) return {(wide ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF), 2'b10};
    v = longint'(r);
    return {64'(v), 1'b0, (r != x)};
  endfunction

  task automatic fail_line(input string tag, input string what,
                           input logic [65:0] act, input logic [65:0] expv);
    n_fail++;
    $display("FAIL %s %s actual=%h/%b%b expected=%h/%b%b", tag, what,
             act[65:2], act[1], act[0], expv[65:2], expv[1], expv[0]);
  endtask

  task automatic cycle_begin();
    @(negedge clk);
    drv_cyc++;
    out_ready = stall_en ? ((drv_cyc % 5) != 3) : 1'b1;
    in_valid  = 1'b0;
  endtask

  // Checks made each clock, before the coming edge
  task automatic cycle_end(output bit accepted);
    logic [65:0] e;
    string t;
    #2;
    n_tests++;  // R1 ready rule
    if (in_ready !== (!out_valid || out_ready))
      fail_line("R1", "in_ready", {63'b0, in_ready, 2'b0}, {63'b0, (!out_valid || out_ready), 2'b0});
    n_tests++;  // R1 output present exactly when one is owed
    if (out_valid !== (exp_q.size() != 0))
      fail_line("R1", "out_valid", {63'b0, out_valid, 2'b0}, {63'b0, (exp_q.size() != 0), 2'b0});
    if (out_valid && out_ready && exp_q.size() != 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if ({out_result, out_invalid, out_inexact} !== e)
        fail_line(t, "result", {out_result, out_invalid, out_inexact}, e);
    end
    accepted = in_valid && in_ready;
    if (accepted) begin
      exp_q.push_back(model(in_operand, in_op, in_wide, in_rmode));
      tag_q.push_back(cur_tag);
    end
  endtask

  task automatic send(input logic [63:0] b, input logic [2:0] op, input logic wide,
                      input logic [1:0] rm, input string tag);
    bit acc;
    cycle_begin();
    in_valid = 1'b1; in_operand = b; in_op = op; in_wide = wide; in_rmode = rm;
    cur_tag = tag;
    cycle_end(acc);
    while (!acc) begin
      cycle_begin();
      in_valid = 1'b1;
      cycle_end(acc);
    end
  endtask

  task automatic sendr(input real x, input logic [2:0] op, input logic wide, input string tag);
    send($realtobits(x), op, wide, 2'd0, tag);
  endtask

  task automatic drain();
    bit acc;
    for (int k = 0; k < 8; k++) begin
      cycle_begin();
      cycle_end(acc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    n_tests++;  // R10 reset state
    if (out_valid !== 1'b0 || in_ready !== 1'b1)
      fail_line("R10", "reset", {62'b0, out_valid, in_ready, 2'b0}, {62'b0, 2'b01, 2'b0});
    rst_n = 1'b1;

    // R2 ties to even at 32 bits
    sendr(2.5, 3'd0, 1'b0, "R2");  sendr(3.5, 3'd0, 1'b0, "R2");
    sendr(-2.5, 3'd0, 1'b0, "R2"); sendr(2.4, 3'd0, 1'b0, "R2");
    sendr(-2.6, 3'd0, 1'b0, "R2"); sendr(0.5, 3'd0, 1'b0, "R2");
    // R3 ties away at 64 bits
    sendr(2.5, 3'd0, 1'b1, "R3");  sendr(-2.5, 3'd0, 1'b1, "R3");
    sendr(0.5, 3'd0, 1'b1, "R3");  sendr(-3.25, 3'd0, 1'b1, "R3");
    // R4 directed rounding
    for (int w = 0; w < 2; w++) begin
      sendr(1.5, 3'd1, w[0], "R4");  sendr(-1.5, 3'd1, w[0], "R4");
      sendr(1.5, 3'd2, w[0], "R4");  sendr(-1.5, 3'd2, w[0], "R4");
      sendr(1.5, 3'd3, w[0], "R4");  sendr(-1.5, 3'd3, w[0], "R4");
    end
    // R5 convert follows mode 0, other modes invalid
    sendr(2.5, 3'd4, 1'b0, "R5");  sendr(2.5, 3'd4, 1'b1, "R5");
    send($realtobits(7.0), 3'd4, 1'b0, 2'd1, "R5");
    send($realtobits(7.0), 3'd4, 1'b1, 2'd3, "R5");
    // R6 range and non-finite
    sendr(2147483647.0, 3'd1, 1'b0, "R6");  sendr(2147483648.0, 3'd1, 1'b0, "R6");
    sendr(-2147483648.0, 3'd1, 1'b0, "R6"); sendr(-2147483648.5, 3'd1, 1'b0, "R6");
    sendr(-2147483648.5, 3'd2, 1'b0, "R6"); sendr(2147483647.5, 3'd0, 1'b0, "R6");
    sendr(9223372036854775808.0, 3'd1, 1'b1, "R6");
    sendr(-9223372036854775808.0, 3'd1, 1'b1, "R6");
    sendr(1.0e10, 3'd1, 1'b0, "R6"); sendr(1.0e10, 3'd1, 1'b1, "R6");
    send(64'h7FF8_0000_0000_0000, 3'd0, 1'b1, 2'd0, "R6");
    send(64'h7FF0_0000_0000_0000, 3'd2, 1'b0, 2'd0, "R6");
    send(64'hFFF0_0000_0000_0000, 3'd3, 1'b1, 2'd0, "R6");
    // R7 exact vs inexact
    sendr(42.0, 3'd0, 1'b0, "R7"); sendr(42.125, 3'd1, 1'b1, "R7");
    // R8 sign extension of narrow results
    sendr(-7.0, 3'd1, 1'b0, "R8"); sendr(-7.0, 3'd1, 1'b1, "R8");
    // R9 reserved operation codes
    sendr(1.0, 3'd5, 1'b0, "R9"); sendr(1.0, 3'd7, 1'b1, "R9");
    // R11 signed zero and subnormals
    send(64'h8000_0000_0000_0000, 3'd2, 1'b0, 2'd0, "R11");
    send(64'h0000_0000_0000_0000, 3'd3, 1'b1, 2'd0, "R11");
    send(64'h0000_0000_0000_0001, 3'd3, 1'b0, 2'd0, "R11");
    send(64'h8000_0000_0000_0001, 3'd2, 1'b1, 2'd0, "R11");
    send(64'h8000_0000_0000_0001, 3'd0, 1'b0, 2'd0, "R11");
    drain();

    // R1 back-pressure with mixed random traffic
    stall_en = 1;
    for (int i = 0; i < 400; i++) begin
      real x;
      x = (real'($urandom_range(4000000)) - 2000000.0) / 16.0;
      if (i % 3 == 0) x = x * 4096.0;
      send($realtobits(x), 3'($urandom_range(4)), 1'($urandom_range(1)), 2'd0, "R1");
    end
    drain();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule